// File: doc/BRIEF.md
# Testable Microprogram Sequencer with Control-Store Self-Test

This block fetches microinstructions. A microprogram counter addresses a constant control store, and each fetched word is captured in a microinstruction register. In normal operation the next address comes from an incrementor, from a jump address, from a conditional branch, or from the current address (hold). The choice is made by a two-bit select input.

A test mode reaches every control-store word without a separate counter and without scan on every flop. While test mode is high, the next-address multiplexer always takes the incrementor output, so the counter and incrementor form an exhaustive address counter. The microinstruction register also gains a right-shift function. For each address the register loads the word in parallel, then shifts it out, least significant bit first, on a dedicated serial pin. A valid flag marks the serial bits. A done flag reports that the counter has wrapped back to address zero. With test mode low, the added logic has no effect, and the sequencer behaves as it would without it.

Top module: `useq_top`

## Requirements
- R1: While reset is high, the counter, the microinstruction register, the serial valid flag and the done flag all go to zero on each clock.
- R2: With test mode low, the counter takes a new value on every clock, chosen by the select input. The codes are 2'b00 for address+1 (wrapping), 2'b01 for the jump address, 2'b10 for the jump address when the condition input is 1 (otherwise address+1), and 2'b11 to hold the address.
- R3: With test mode low, each clock loads the microinstruction register with the word at the current address. The word stored at address a is the low WW bits of ((a*37 + 0x5A3C) XOR (a<<9)), computed in 32 bits.
- R4: With test mode high, the select, jump address and condition inputs are ignored. The counter either holds or advances by exactly one.
- R5: In test mode, each address takes one load cycle followed by WW shift cycles, during which the serial valid flag is high. The counter advances at the end of the last shift cycle, so a full pass over 2^AW addresses takes 2^AW*(WW+1) cycles.
- R6: During the shift cycles, the serial output carries the captured word least significant bit first. The serial output is 0 whenever the valid flag is low.
- R7: Starting from address 0, a test pass delivers every address in ascending order, each exactly once.
- R8: The done flag sets on the clock where the counter wraps from the highest address to 0 in test mode. It stays set while test mode stays high, and it clears on the first clock with test mode low.
- R9: Leaving test mode restores normal sequencing at once. Re-entering test mode starts with a load of the word at the current address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| test_mode_i | input | 1 | Selects the control-store self-test |
| sel_i | input | 2 | Next-address select (normal mode) |
| jump_addr_i | input | AW | Jump/branch target |
| cond_i | input | 1 | Branch condition |
| upc_o | output | AW | Current microprogram address |
| uir_o | output | WW | Microinstruction register contents |
| scan_out_o | output | 1 | Serial control-store data, least significant bit first |
| scan_valid_o | output | 1 | High while scan_out_o carries a data bit |
| test_done_o | output | 1 | Set after the test pass wraps to address 0 |

## Verification
The bench builds the block with AW=4 and WW=12. A complete pass of 16 words then takes 208 cycles, so the address wrap and the done flag come within reach well inside the run. The bench also leaves test mode mid-word and re-enters it. A scoreboard queues the expected address and word for each test step. The monitor rebuilds every word from the serial stream and compares both. Normal-mode steps cover each select code, a taken and an untaken branch, a hold, and counter wrap.

// File: rtl/useq_pkg.sv
package useq_pkg;

    typedef enum logic [1:0] {
        SEL_INC    = 2'b00,
        SEL_JUMP   = 2'b01,
        SEL_BRANCH = 2'b10,
        SEL_HOLD   = 2'b11
    } nxt_sel_e;

    typedef enum logic {
        PH_LOAD  = 1'b0,
        PH_SHIFT = 1'b1
    } tphase_e;

    // control bundle from the test controller to the datapath
    typedef struct packed {
        logic load;   // parallel capture into the microinstruction register
        logic shift;  // right shift of the microinstruction register
        logic step;   // counter update enable
    } seq_ctl_t;

    // control-store contents as a closed-form function of the address
    function automatic logic [31:0] store_word(input logic [31:0] a);
        return (a * 32'd37 + 32'h0000_5A3C) ^ (a << 9);
    endfunction

endpackage

// File: rtl/useq_nextaddr.sv
module useq_nextaddr
    import useq_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic [AW-1:0] upc_i,
    input  logic [1:0]    sel_i,
    input  logic [AW-1:0] jump_addr_i,
    input  logic          cond_i,
    input  logic          force_inc_i,
    output logic [AW-1:0] nxt_o
);
    logic [AW-1:0] incr;
    nxt_sel_e      sel;

    assign incr = upc_i + AW'(1);
    assign sel  = force_inc_i ? SEL_INC : nxt_sel_e'(sel_i);

    always_comb begin
        unique case (sel)
            SEL_INC:    nxt_o = incr;
            SEL_JUMP:   nxt_o = jump_addr_i;
            SEL_BRANCH: nxt_o = cond_i ? jump_addr_i : incr;
            default:    nxt_o = upc_i;
        endcase
    end
endmodule

// File: rtl/useq_store.sv
module useq_store
    import useq_pkg::*;
#(
    parameter int AW = 5,
    parameter int WW = 16
) (
    input  logic [AW-1:0] addr_i,
    output logic [WW-1:0] data_o
);
    localparam int DEPTH = 1 << AW;

    logic [WW-1:0] table_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        localparam logic [31:0] FULL = store_word(32'(i));
        assign table_q[i] = FULL[WW-1:0];
    end

    assign data_o = table_q[addr_i];
endmodule

// File: rtl/useq_uir.sv
module useq_uir #(
    parameter int WW = 16
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          load_i,
    input  logic          shift_i,
    input  logic [WW-1:0] d_i,
    output logic [WW-1:0] q_o
);
    always_ff @(posedge clk_i) begin
        if (rst_i)        q_o <= '0;
        else if (load_i)  q_o <= d_i;
        else if (shift_i) q_o <= {1'b0, q_o[WW-1:1]};
    end
endmodule

// File: rtl/useq_test_ctl.sv
module useq_test_ctl
    import useq_pkg::*;
#(
    parameter int AW = 5,
    parameter int WW = 16
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          test_mode_i,
    input  logic [AW-1:0] upc_i,
    output seq_ctl_t      ctl_o,
    output logic          scan_valid_o,
    output logic          done_o
);
    localparam int            CW   = (WW > 2) ? $clog2(WW) : 1;
    localparam logic [CW-1:0] LAST = CW'(WW - 1);

    tphase_e       phase;
    logic [CW-1:0] cnt;
    logic          last_bit;

    assign last_bit = (phase == PH_SHIFT) && (cnt == LAST);

    always_ff @(posedge clk_i) begin
        if (rst_i || !test_mode_i) begin
            phase  <= PH_LOAD;
            cnt    <= '0;
            done_o <= 1'b0;
        end else if (phase == PH_LOAD) begin
            phase <= PH_SHIFT;
            cnt   <= '0;
        end else if (last_bit) begin
            phase <= PH_LOAD;
            cnt   <= '0;
            if (upc_i == '1) done_o <= 1'b1;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

    always_comb begin
        ctl_o.load   = !test_mode_i || (phase == PH_LOAD);
        ctl_o.shift  = test_mode_i && (phase == PH_SHIFT);
        ctl_o.step   = !test_mode_i || last_bit;
        scan_valid_o = ctl_o.shift;
    end
endmodule

// File: rtl/useq_top.sv
module useq_top
    import useq_pkg::*;
#(
    parameter int AW = 5,
    parameter int WW = 16
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          test_mode_i,
    input  logic [1:0]    sel_i,
    input  logic [AW-1:0] jump_addr_i,
    input  logic          cond_i,
    output logic [AW-1:0] upc_o,
    output logic [WW-1:0] uir_o,
    output logic          scan_out_o,
    output logic          scan_valid_o,
    output logic          test_done_o
);
    seq_ctl_t      ctl;
    logic [AW-1:0] nxt;
    logic [WW-1:0] rom_word;

    useq_nextaddr #(.AW(AW)) u_nxt (
        .upc_i       (upc_o),
        .sel_i       (sel_i),
        .jump_addr_i (jump_addr_i),
        .cond_i      (cond_i),
        .force_inc_i (test_mode_i),
        .nxt_o       (nxt)
    );

    useq_store #(.AW(AW), .WW(WW)) u_store (
        .addr_i (upc_o),
        .data_o (rom_word)
    );

    useq_test_ctl #(.AW(AW), .WW(WW)) u_ctl (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .test_mode_i  (test_mode_i),
        .upc_i        (upc_o),
        .ctl_o        (ctl),
        .scan_valid_o (scan_valid_o),
        .done_o       (test_done_o)
    );

    useq_uir #(.WW(WW)) u_uir (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .load_i  (ctl.load),
        .shift_i (ctl.shift),
        .d_i     (rom_word),
        .q_o     (uir_o)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i)         upc_o <= '0;
        else if (ctl.step) upc_o <= nxt;
    end

    assign scan_out_o = scan_valid_o & uir_o[0];
endmodule

// File: rtl/useq_checker.sv
module useq_checker #(
    parameter int AW = 5,
    parameter int WW = 16
) (
    input logic          clk_i,
    input logic          rst_i,
    input logic          test_mode_i,
    input logic [1:0]    sel_i,
    input logic [AW-1:0] jump_addr_i,
    input logic [AW-1:0] upc_o,
    input logic [WW-1:0] uir_o,
    input logic [WW-1:0] rom_word,
    input logic          scan_out_o,
    input logic          scan_valid_o,
    input logic          test_done_o
);
    p_reset_r1: assert property (@(posedge clk_i)
        rst_i |=> (upc_o == '0 && uir_o == '0 && !scan_valid_o && !test_done_o));

    p_inc_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (!test_mode_i && sel_i == 2'b00) |=> upc_o == ($past(upc_o) + AW'(1)));

    p_jump_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (!test_mode_i && sel_i == 2'b01) |=> upc_o == $past(jump_addr_i));

    p_hold_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (!test_mode_i && sel_i == 2'b11) |=> $stable(upc_o));

    p_load_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        !test_mode_i |=> uir_o == $past(rom_word));

    p_test_count_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        test_mode_i |=> (upc_o == ($past(upc_o) + AW'(1)) || $stable(upc_o)));

    p_valid_in_test_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        scan_valid_o |-> test_mode_i);

    p_quiet_serial_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        !scan_valid_o |-> !scan_out_o);

    p_done_sticky_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (test_done_o && test_mode_i) |=> test_done_o);

    p_done_clear_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        !test_mode_i |=> !test_done_o);
endmodule

bind useq_top useq_checker #(.AW(AW), .WW(WW)) u_chk (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .test_mode_i  (test_mode_i),
    .sel_i        (sel_i),
    .jump_addr_i  (jump_addr_i),
    .upc_o        (upc_o),
    .uir_o        (uir_o),
    .rom_word     (rom_word),
    .scan_out_o   (scan_out_o),
    .scan_valid_o (scan_valid_o),
    .test_done_o  (test_done_o)
);

// File: tb/sim_useq_top.sv
module sim_useq_top;
    localparam int AW = 4;
    localparam int WW = 12;
    localparam int NW = 1 << AW;

    logic          clk = 1'b0;
    logic          rst;
    logic          tm;
    logic [1:0]    sel;
    logic [AW-1:0] ja;
    logic          cond;
    logic [AW-1:0] upc;
    logic [WW-1:0] uir;
    logic          sout, svalid, done;

    always #10 clk = ~clk;

    useq_top #(.AW(AW), .WW(WW)) u0 (
        .clk_i(clk), .rst_i(rst), .test_mode_i(tm), .sel_i(sel),
        .jump_addr_i(ja), .cond_i(cond), .upc_o(upc), .uir_o(uir),
        .scan_out_o(sout), .scan_valid_o(svalid), .test_done_o(done)
    );

    int checks = 0;
    int fails  = 0;

    typedef struct { int addr; logic [WW-1:0] word; } item_t;
    item_t exp_q[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [WW-1:0] ref_word(input int a);
        logic [31:0] x;
        x = 32'(a);
        x = (x * 32'd37 + 32'h0000_5A3C) ^ (x << 9);
        return x[WW-1:0];
    endfunction

    // monitor: rebuild words from the serial stream and score them
    int          bitcnt = 0;
    int          words_seen = 0;
    int          valid_bits = 0;
    logic [WW-1:0] shreg = '0;

    always @(negedge clk) begin
        item_t it;
        if (rst || !tm) begin
            bitcnt = 0;
        end else if (svalid) begin
            shreg[bitcnt] = sout;
            bitcnt++;
            valid_bits++;
            if (bitcnt == WW) begin
                bitcnt = 0;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7", "unexpected serial word", int'(shreg), 0);
                end else begin
                    it = exp_q.pop_front();
                    chk(shreg == it.word, "R6", "serial word", int'(shreg), int'(it.word));
                    chk(int'(upc) == it.addr, "R4", "address while shifting", int'(upc), it.addr);
                    words_seen++;
                end
            end
        end
    end

    int exp_upc;

    task automatic norm_step(input logic [1:0] s, input int j, input bit c);
        int prev;
        sel = s; ja = AW'(j); cond = c;
        prev = exp_upc;
        case (s)
            2'b00: exp_upc = (prev + 1) % NW;
            2'b01: exp_upc = j;
            2'b10: exp_upc = c ? j : (prev + 1) % NW;
            default: exp_upc = prev;
        endcase
        @(posedge clk);
        @(negedge clk);
        chk(int'(upc) == exp_upc, "R2", "next address", int'(upc), exp_upc);
        chk(uir == ref_word(prev), "R3", "microinstruction", int'(uir), int'(ref_word(prev)));
        chk(!svalid && !sout, "R6", "serial idle in normal mode", int'({svalid, sout}), 0);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int cyc;
        int w0;
        item_t it;
        rst = 1'b1; tm = 1'b0; sel = 2'b00; ja = '0; cond = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(upc == '0 && uir == '0, "R1", "reset address/register", int'(upc), 0);
        chk(!svalid && !done && !sout, "R1", "reset flags", int'({svalid, done, sout}), 0);

        // normal sequencing
        rst = 1'b0; exp_upc = 0;
        norm_step(2'b00, 0, 1'b0);
        norm_step(2'b00, 0, 1'b0);
        norm_step(2'b00, 0, 1'b0);
        norm_step(2'b01, 13, 1'b0);
        norm_step(2'b10, 3, 1'b0);   // branch not taken
        norm_step(2'b10, 2, 1'b1);   // branch taken
        norm_step(2'b11, 9, 1'b1);   // hold
        norm_step(2'b01, 15, 1'b0);
        norm_step(2'b00, 0, 1'b0);   // wrap to 0

        // full self-test pass with misleading selects held (R4)
        @(negedge clk);
        rst = 1'b1; tm = 1'b1; sel = 2'b01; ja = AW'(7); cond = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int a = 0; a < NW; a++) begin
            it.addr = a; it.word = ref_word(a);
            exp_q.push_back(it);
        end
        valid_bits = 0; words_seen = 0;
        cyc = 0;
        while (!done && cyc < 400) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
        end
        chk(cyc == NW * (WW + 1), "R5", "cycles to done", cyc, NW * (WW + 1));
        chk(valid_bits == NW * WW, "R5", "valid serial bits", valid_bits, NW * WW);
        chk(words_seen == NW && exp_q.size() == 0, "R7", "words delivered", words_seen, NW);
        chk(upc == '0, "R8", "address after wrap", int'(upc), 0);

        repeat (5) begin @(posedge clk); @(negedge clk); end
        chk(done == 1'b1, "R8", "done held in test mode", int'(done), 1);
        chk(upc == '0, "R4", "no step mid-word", int'(upc), 0);

        // leave test mode mid-word
        tm = 1'b0; exp_upc = 0;
        norm_step(2'b00, 0, 1'b0);
        chk(done == 1'b0, "R8", "done cleared", int'(done), 0);

        // re-enter: load of current address first (R9), selects ignored (R4)
        sel = 2'b01; ja = AW'(9); cond = 1'b1;
        tm = 1'b1;
        it.addr = 1; it.word = ref_word(1);
        exp_q.push_back(it);
        w0 = words_seen;
        repeat (WW + 1) @(posedge clk);
        @(negedge clk);
        chk(words_seen == w0 + 1, "R9", "word after re-entry", words_seen, w0 + 1);
        chk(int'(upc) == 2, "R9", "address after re-entry word", int'(upc), 2);
        chk(!svalid, "R5", "load cycle has no valid bit", int'(svalid), 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule